// File: doc/BRIEF.md
# Transmit descriptor ring engine

This block walks a circular list of transmit descriptors kept in a shared 16-bit word memory. When the host hands an entry over by setting its ownership flag, the engine fetches the entry's buffer pointer and length and streams the buffer out one byte at a time on a valid/ready output. It then collects the outcome from a small set of MAC status inputs, writes the completion status into the entry, and hands the entry back to the host. Scanning goes on entry after entry and stops at the first entry the host still holds.

The engine looks at the ring every `POLL_CYCLES` idle cycles. A transmit-demand pulse starts a look at once. Each finished entry gives a one-cycle `tx_done` pulse, which is meant to set a transmit interrupt flag elsewhere. The ring base and ring size come from two configuration words. The ring size is stored as a log2 value, so the ring always has a power-of-two number of entries.

Top module: `txr_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_valid`, `mem_en` and `tx_done` are low.
- R2: A scan first reads the entry's flag word. If bit 15 of that word (ownership, flag value 0x80) is 0, the scan ends: no further memory access, no output byte, no write-back, and the index stays where it is.
- R3: Entry i starts at word address (byte ring base >> 1) + 4*i. The byte ring base is {`ring_cfg`[7:0], `ring_base_lo`}. Word +0 holds buffer address bits 15:0. Word +1 holds the flag byte in [15:8] and buffer address bits 23:16 in [7:0]. Word +2 holds the length. Word +3 is the status word.
- R4: The length word holds the byte count negated in two's complement. The count is (-word) mod 4096, and a result of 0 means 4096. The bytes go out in address order, starting at the byte address of the buffer. The even byte of a memory word is its bits [15:8]. `tx_last` marks only the final byte. Data is held while `tx_valid` is high and `tx_ready` is low.
- R5: Completion writes the status word first and the flag word last. The flag word has bit 15 cleared and keeps bits 9:8 (start/end-of-packet flags) and bits 7:0. `tx_done` pulses for one cycle right after the flag write.
- R6: A retry count of exactly 1 sets flag word bit 11 (0x08). A count of 2 or more sets bit 12 (0x10). A count of 16 or more also sets status bit 10 and counts as an error.
- R7: Lost carrier sets status bit 11, late collision sets bit 12 and underflow sets bit 14. Any error sets flag word bit 14 (0x40). Status bits 9:0 carry `mac_tdr`.
- R8: An entry whose end-of-packet flag (flag word bit 8) is 0 sends no bytes. It is completed with status word 0x8000 and the error bit set in its flag word.
- R9: The index advances modulo 2^`ring_cfg`[15:13]. After the last entry, the scan moves on to entry 0.
- R10: Once an entry is handed back, the next entry is read at once, with no wait for a poll.
- R11: While idle and running, the engine scans every `POLL_CYCLES` cycles. A `poll_demand` pulse puts the flag read on the memory port in the cycle after it is sampled.
- R12: While `run` is low, the engine makes no memory access and sends no bytes. Any entry in progress is dropped, and the index returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Engine enable; low stops it and rewinds the index |
| poll_demand | input | 1 | Start a scan now |
| ring_base_lo | input | 16 | Ring base byte address, bits 15:0 |
| ring_cfg | input | 16 | [15:13] log2 ring size, [7:0] ring base bits 23:16 |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 23 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| tx_data | output | 8 | Output byte |
| tx_valid | output | 1 | Output byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| mac_done | input | 1 | MAC status below is valid |
| mac_retries | input | 5 | Retries used for the frame |
| mac_lost_carrier | input | 1 | Carrier lost |
| mac_late_collision | input | 1 | Late collision |
| mac_underflow | input | 1 | Data arrived too late |
| mac_tdr | input | 10 | Cable-test count |
| tx_done | output | 1 | One-cycle pulse after an entry is returned |

## Verification
A wrong index or a wrong ring mask shows at the memory port within a scan, because a flag read goes to the wrong word address. A fault in the byte pointer or the byte counter shows on the byte stream within a few bytes, as a wrong byte, a misplaced `tx_last` or an extra byte. Faulty status packing shows in the two write-back words at the end of the same entry. A write-back order that is out of step shows as the ownership write no longer being last before `tx_done`.

// File: rtl/txr_pkg.sv
// Package txr_pkg
// Shared constants and state types for the transmit descriptor ring engine.
// Assumes a fixed descriptor format of four 16-bit words per entry.
package txr_pkg;

    // Word offsets inside one descriptor
    localparam int OFS_ADDR = 0;
    localparam int OFS_FLAG = 1;
    localparam int OFS_LEN  = 2;
    localparam int OFS_MISC = 3;
    localparam int DESC_WORDS_LOG = 2;

    // Bit positions inside the flag byte
    localparam int FL_ENP  = 0;
    localparam int FL_STP  = 1;
    localparam int FL_ONE  = 3;
    localparam int FL_MORE = 4;
    localparam int FL_ERR  = 6;
    localparam int FL_OWN  = 7;

    // Bit positions inside the status word
    localparam int MS_RTRY = 10;
    localparam int MS_LCAR = 11;
    localparam int MS_LCOL = 12;
    localparam int MS_UFLO = 14;
    localparam int MS_BUFF = 15;
    localparam int TDR_W   = 10;

    // Retry count at or above which a frame is a failure
    localparam int RETRY_W     = 5;
    localparam int RETRY_LIMIT = 16;

    // Length field width and byte address width
    localparam int LEN_W     = 12;
    localparam int BYTE_AW   = 24;
    localparam int LOG_W     = 3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RFLAG,
        S_CFLAG,
        S_RADDR,
        S_CADDR,
        S_RLEN,
        S_CLEN,
        S_STREAM,
        S_STATUS,
        S_WMISC,
        S_WOWN,
        S_NEXT
    } eng_state_t;

    typedef enum logic [1:0] {
        B_IDLE,
        B_FETCH,
        B_LOAD,
        B_SEND
    } ser_state_t;

endpackage

// File: rtl/txr_poll_timer.sv
// Module txr_poll_timer
// Periodic poll tick generator. Counts while enabled, and a tick lasts
// one cycle after POLL_CYCLES enabled cycles. Dropping enable restarts
// the count. Assumes POLL_CYCLES >= 2.
module txr_poll_timer #(
    parameter int POLL_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int CW = $clog2(POLL_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // count enabled cycles and wrap at the poll period
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // tick in the final cycle of each period
    assign tick = enable && (cnt_q == LAST);

    // R11: a tick never lasts more than one cycle
    a_r11_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/txr_byte_ser.sv
// Module txr_byte_ser
// Reads a buffer word by word from the shared memory and emits it as a
// byte stream with valid/ready. Even byte addresses map to bits [15:8].
// Assumes one-cycle read latency and that it owns the memory port while
// busy. Start addresses may be odd.
module txr_byte_ser
    import txr_pkg::*;
#(
    parameter int AW = BYTE_AW,
    parameter int NW = LEN_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [NW-1:0] nbytes,
    output logic          rd_en,
    output logic [AW-2:0] rd_addr,
    input  logic [15:0]   rd_data,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic          fin
);
    ser_state_t    st_q;
    logic [AW-1:0] ptr_q;
    logic [NW-1:0] rem_q;
    logic [15:0]   word_q;

    // walk the buffer: fetch a word, hold it, hand out its bytes
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            st_q   <= B_IDLE;
            ptr_q  <= '0;
            rem_q  <= '0;
            word_q <= '0;
        end else begin
            unique case (st_q)
                B_IDLE: begin
                    if (start) begin
                        ptr_q <= start_addr;
                        rem_q <= nbytes;
                        st_q  <= B_FETCH;
                    end
                end
                B_FETCH: st_q <= B_LOAD;
                B_LOAD: begin
                    word_q <= rd_data;
                    st_q   <= B_SEND;
                end
                B_SEND: begin
                    if (tx_ready) begin
                        rem_q <= rem_q - 1'b1;
                        ptr_q <= ptr_q + 1'b1;
                        if (rem_q == NW'(1)) begin
                            st_q <= B_IDLE;
                        end else if (ptr_q[0]) begin
                            st_q <= B_FETCH;
                        end
                    end
                end
                default: st_q <= B_IDLE;
            endcase
        end
    end

    // memory request and byte output decode
    always_comb begin
        rd_en    = (st_q == B_FETCH);
        rd_addr  = ptr_q[AW-1:1];
        tx_valid = (st_q == B_SEND);
        tx_data  = ptr_q[0] ? word_q[7:0] : word_q[15:8];
        tx_last  = tx_valid && (rem_q == NW'(1));
        fin      = tx_valid && tx_ready && (rem_q == NW'(1));
    end

    // R4: an offered byte stays unchanged until it is taken
    a_r4_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !abort) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R4: the end mark only appears with a valid byte
    a_r4_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

endmodule

// File: rtl/txr_wb_pack.sv
// Module txr_wb_pack
// Builds the two completion words from the latched MAC outcome: the
// status word and the flag word with ownership cleared. Purely
// combinational.
module txr_wb_pack
    import txr_pkg::*;
(
    input  logic [7:0]         flags_in,
    input  logic [7:0]         addr_hi,
    input  logic               buf_err,
    input  logic [RETRY_W-1:0] retries,
    input  logic               lost_carrier,
    input  logic               late_collision,
    input  logic               underflow,
    input  logic [TDR_W-1:0]   tdr,
    output logic [15:0]        flag_word,
    output logic [15:0]        misc_word
);
    logic       one_retry;
    logic       many_retry;
    logic       retry_fail;
    logic       any_err;
    logic [7:0] fl;

    // classify the outcome and assemble both words
    always_comb begin
        one_retry  = (retries == RETRY_W'(1));
        many_retry = (retries >= RETRY_W'(2));
        retry_fail = (retries >= RETRY_W'(RETRY_LIMIT));
        any_err    = retry_fail || lost_carrier || late_collision || underflow || buf_err;

        fl          = '0;
        fl[FL_ENP]  = flags_in[FL_ENP];
        fl[FL_STP]  = flags_in[FL_STP];
        fl[FL_ONE]  = one_retry;
        fl[FL_MORE] = many_retry;
        fl[FL_ERR]  = any_err;
        fl[FL_OWN]  = 1'b0;
        flag_word   = {fl, addr_hi};

        misc_word           = '0;
        misc_word[TDR_W-1:0] = tdr;
        misc_word[MS_RTRY]  = retry_fail;
        misc_word[MS_LCAR]  = lost_carrier;
        misc_word[MS_LCOL]  = late_collision;
        misc_word[MS_UFLO]  = underflow;
        misc_word[MS_BUFF]  = buf_err;
    end

endmodule

// File: rtl/txr_engine.sv
// Module txr_engine
// Transmit descriptor ring engine. Polls a power-of-two ring of 4-word
// descriptors, streams owned buffers as bytes, writes status back and
// hands each entry to the host with the ownership write last.
// Assumes a 16-bit word memory with one-cycle read latency and no wait
// states, configuration words stable while run is high, and a 24-bit
// byte address space.
module txr_engine
    import txr_pkg::*;
#(
    parameter int POLL_CYCLES = 2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 poll_demand,
    input  logic [15:0]          ring_base_lo,
    input  logic [15:0]          ring_cfg,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [BYTE_AW-2:0]   mem_addr,
    output logic [15:0]          mem_wdata,
    input  logic [15:0]          mem_rdata,
    output logic [7:0]           tx_data,
    output logic                 tx_valid,
    output logic                 tx_last,
    input  logic                 tx_ready,
    input  logic                 mac_done,
    input  logic [RETRY_W-1:0]   mac_retries,
    input  logic                 mac_lost_carrier,
    input  logic                 mac_late_collision,
    input  logic                 mac_underflow,
    input  logic [TDR_W-1:0]     mac_tdr,
    output logic                 tx_done
);
    localparam int WAW   = BYTE_AW - 1;
    localparam int IDX_W = (1 << LOG_W) - 1;
    localparam int NW    = LEN_W + 1;

    eng_state_t         state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [7:0]         flags_q;
    logic [7:0]         hi_q;
    logic [15:0]        lo_q;
    logic               buf_err_q;
    logic [RETRY_W-1:0] retries_q;
    logic               lcar_q;
    logic               lcol_q;
    logic               uflo_q;
    logic [TDR_W-1:0]   tdr_q;

    logic [LOG_W-1:0]   ring_log;
    logic [IDX_W:0]     one_sh;
    logic [IDX_W-1:0]   idx_mask;
    logic [BYTE_AW-1:0] ring_byte;
    logic [WAW-1:0]     desc_base;
    logic [15:0]        neg_len;
    logic [NW-1:0]      frame_len;
    logic               poll_tick;
    logic               ser_start;
    logic               ser_rd;
    logic [WAW-1:0]     ser_addr;
    logic               ser_fin;
    logic [15:0]        flag_word;
    logic [15:0]        misc_word;
    logic               unused_cfg;

    assign unused_cfg = ^ring_cfg[12:8];

    // ring geometry and the current descriptor address
    always_comb begin
        ring_log  = ring_cfg[15:13];
        one_sh    = (IDX_W + 1)'(1) << ring_log;
        idx_mask  = IDX_W'(one_sh - 1'b1);
        ring_byte = {ring_cfg[7:0], ring_base_lo};
        desc_base = ring_byte[BYTE_AW-1:1] + WAW'({idx_q, 2'b00});
        neg_len   = 16'd0 - mem_rdata;
        frame_len = (neg_len[LEN_W-1:0] == '0) ? NW'(1 << LEN_W) : {1'b0, neg_len[LEN_W-1:0]};
    end

    // periodic poll runs only while idle and enabled
    txr_poll_timer #(
        .POLL_CYCLES(POLL_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(run && (state_q == S_IDLE)),
        .tick  (poll_tick)
    );

    assign ser_start = run && (state_q == S_CLEN) && flags_q[FL_ENP];

    // buffer reader and byte output
    txr_byte_ser #(
        .AW(BYTE_AW),
        .NW(NW)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (!run),
        .start     (ser_start),
        .start_addr({hi_q, lo_q}),
        .nbytes    (frame_len),
        .rd_en     (ser_rd),
        .rd_addr   (ser_addr),
        .rd_data   (mem_rdata),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready),
        .fin       (ser_fin)
    );

    // completion word builder
    txr_wb_pack u_pack (
        .flags_in      (flags_q),
        .addr_hi       (hi_q),
        .buf_err       (buf_err_q),
        .retries       (retries_q),
        .lost_carrier  (lcar_q),
        .late_collision(lcol_q),
        .underflow     (uflo_q),
        .tdr           (tdr_q),
        .flag_word     (flag_word),
        .misc_word     (misc_word)
    );

    // descriptor sequencer: scan, fetch, stream, write back, advance
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state_q   <= S_IDLE;
            idx_q     <= '0;
            flags_q   <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            buf_err_q <= 1'b0;
            retries_q <= '0;
            lcar_q    <= 1'b0;
            lcol_q    <= 1'b0;
            uflo_q    <= 1'b0;
            tdr_q     <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (poll_demand || poll_tick) state_q <= S_RFLAG;
                end
                S_RFLAG: begin
                    buf_err_q <= 1'b0;
                    retries_q <= '0;
                    lcar_q    <= 1'b0;
                    lcol_q    <= 1'b0;
                    uflo_q    <= 1'b0;
                    tdr_q     <= '0;
                    state_q   <= S_CFLAG;
                end
                S_CFLAG: begin
                    if (!mem_rdata[8 + FL_OWN]) begin
                        state_q <= S_IDLE;
                    end else begin
                        flags_q <= mem_rdata[15:8];
                        hi_q    <= mem_rdata[7:0];
                        state_q <= S_RADDR;
                    end
                end
                S_RADDR: state_q <= S_CADDR;
                S_CADDR: begin
                    lo_q    <= mem_rdata;
                    state_q <= S_RLEN;
                end
                S_RLEN: state_q <= S_CLEN;
                S_CLEN: begin
                    if (flags_q[FL_ENP]) begin
                        state_q <= S_STREAM;
                    end else begin
                        buf_err_q <= 1'b1;
                        state_q   <= S_WMISC;
                    end
                end
                S_STREAM: begin
                    if (ser_fin) state_q <= S_STATUS;
                end
                S_STATUS: begin
                    if (mac_done) begin
                        retries_q <= mac_retries;
                        lcar_q    <= mac_lost_carrier;
                        lcol_q    <= mac_late_collision;
                        uflo_q    <= mac_underflow;
                        tdr_q     <= mac_tdr;
                        state_q   <= S_WMISC;
                    end
                end
                S_WMISC: state_q <= S_WOWN;
                S_WOWN:  state_q <= S_NEXT;
                S_NEXT: begin
                    idx_q   <= (idx_q + 1'b1) & idx_mask;
                    state_q <= S_RFLAG;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // memory port: descriptor accesses, or the reader while streaming
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_base;
        mem_wdata = '0;
        unique case (state_q)
            S_RFLAG: begin
                mem_en   = 1'b1;
                mem_addr = desc_base + WAW'(OFS_FLAG);
            end
            S_RADDR: begin
                mem_en   = 1'b1;
                mem_addr = desc_base + WAW'(OFS_ADDR);
            end
            S_RLEN: begin
                mem_en   = 1'b1;
                mem_addr = desc_base + WAW'(OFS_LEN);
            end
            S_STREAM: begin
                mem_en   = ser_rd;
                mem_addr = ser_addr;
            end
            S_WMISC: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_base + WAW'(OFS_MISC);
                mem_wdata = misc_word;
            end
            S_WOWN: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_base + WAW'(OFS_FLAG);
                mem_wdata = flag_word;
            end
            default: ;
        endcase
    end

    // completion pulse follows the ownership write
    assign tx_done = (state_q == S_NEXT);

    // R5: every completion pulse comes straight after a memory write
    a_r5_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(mem_en && mem_we));

    // R5: the write just before a completion pulse releases ownership
    a_r5_own_released: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !$past(mem_wdata[8 + FL_OWN]));

    // R12: no memory traffic once the engine has been stopped for a cycle
    a_r12_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> (!mem_en && !tx_valid));

    // R10: a completion is followed at once by the next flag read
    a_r10_rescan_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && run) |=> (mem_en && !mem_we));

endmodule

// File: tb/sim_txr_engine.sv
// Directed bench for txr_engine: a behavioural word memory, a byte sink
// and one task for each scenario.
module sim_txr_engine;
    localparam int POLL = 50;
    localparam logic [15:0] RING_LO = 16'h0100;
    localparam int DESC0 = 16'h0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        poll_demand = 1'b0;
    logic [15:0] ring_base_lo = RING_LO;
    logic [15:0] ring_cfg = {3'd2, 13'd0};
    logic        mem_en;
    logic        mem_we;
    logic [22:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_last;
    logic        tx_ready = 1'b1;
    logic        mac_done = 1'b1;
    logic [4:0]  mac_retries = '0;
    logic        mac_lost_carrier = 1'b0;
    logic        mac_late_collision = 1'b0;
    logic        mac_underflow = 1'b0;
    logic [9:0]  mac_tdr = '0;
    logic        tx_done;

    int total = 0;
    int bad = 0;
    int rdy_mode = 0;

    logic [15:0] mem [0:4095];
    int wr_n = 0;
    int rd_n = 0;
    int cap_n = 0;
    int done_n = 0;
    logic [22:0] wr_a [0:63];
    logic [15:0] wr_d [0:63];
    logic [22:0] rd_a [0:255];
    logic [7:0]  cap_b [0:255];
    logic        cap_l [0:255];

    always #5 clk = ~clk;

    txr_engine #(.POLL_CYCLES(POLL)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .poll_demand(poll_demand),
        .ring_base_lo(ring_base_lo), .ring_cfg(ring_cfg),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .mac_done(mac_done), .mac_retries(mac_retries),
        .mac_lost_carrier(mac_lost_carrier), .mac_late_collision(mac_late_collision),
        .mac_underflow(mac_underflow), .mac_tdr(mac_tdr), .tx_done(tx_done)
    );

    // memory model with logging, byte sink and completion counter
    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            wr_a[wr_n % 64] <= mem_addr;
            wr_d[wr_n % 64] <= mem_wdata;
            wr_n <= wr_n + 1;
        end
        if (mem_en && !mem_we) begin
            mem_rdata <= mem[mem_addr[11:0]];
            rd_a[rd_n % 256] <= mem_addr;
            rd_n <= rd_n + 1;
        end
        if (tx_valid && tx_ready) begin
            cap_b[cap_n % 256] <= tx_data;
            cap_l[cap_n % 256] <= tx_last;
            cap_n <= cap_n + 1;
        end
        if (tx_done) done_n <= done_n + 1;
    end

    // sink readiness pattern
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? cyc[0] : 1'b0;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int j);
        return 8'(seed * 29 + j * 7 + 3);
    endfunction

    // fill a buffer with the pattern, zero outside it within its words
    task automatic fill_buf(input int start, input int n, input int seed);
        for (int w = start / 2; w <= (start + n - 1) / 2; w++) begin
            logic [7:0] hb;
            logic [7:0] lb;
            hb = (2*w >= start && 2*w < start + n) ? pat(seed, 2*w - start) : 8'h00;
            lb = (2*w+1 >= start && 2*w+1 < start + n) ? pat(seed, 2*w + 1 - start) : 8'h00;
            mem[w] <= {hb, lb};
        end
    endtask

    task automatic set_desc(input int i, input int start, input logic [7:0] flags, input int n);
        int d;
        d = DESC0 + 4*i;
        mem[d]     <= 16'(start);
        mem[d + 1] <= {flags, 8'(start >> 16)};
        mem[d + 2] <= (16'd0 - 16'(n)) | 16'hF000;
        mem[d + 3] <= 16'h0000;
    endtask

    // stop, rewind, then restart with a demand pulse
    task automatic kick();
        @(negedge clk);
        run <= 1'b0;
        @(negedge clk);
        run <= 1'b1;
        poll_demand <= 1'b1;
        @(negedge clk);
        poll_demand <= 1'b0;
    endtask

    task automatic wait_done(input int target, input string tag);
        int t = 0;
        while (done_n < target && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(tag, 32'(done_n >= target), 32'd1);
        repeat (8) @(negedge clk);
    endtask

    // one frame in entry 0 with entry 1 host-owned; checks write-back
    task automatic one_frame(input string tag, input logic [7:0] flags, input int start,
                             input int n, input int seed, input logic [4:0] rtry,
                             input logic lcar, input logic lcol, input logic uflo,
                             input logic [9:0] tdr, input logic [15:0] exp_misc,
                             input logic [15:0] exp_flag, input int exp_bytes);
        int w0;
        int c0;
        int d0;
        @(negedge clk);
        run <= 1'b0;
        ring_cfg <= {3'd2, 13'd0};
        set_desc(0, start, flags, n);
        set_desc(1, 16'h0600, 8'h00, 4);
        fill_buf(start, n, seed);
        mac_retries <= rtry;
        mac_lost_carrier <= lcar;
        mac_late_collision <= lcol;
        mac_underflow <= uflo;
        mac_tdr <= tdr;
        @(negedge clk);
        w0 = wr_n;
        c0 = cap_n;
        d0 = done_n;
        kick();
        wait_done(d0 + 1, {tag, " completion"});
        chk({tag, " byte count"}, 32'(cap_n - c0), 32'(exp_bytes));
        for (int j = 0; j < exp_bytes; j++) begin
            chk({tag, " byte"}, {24'd0, cap_b[(c0 + j) % 256]}, {24'd0, pat(seed, j)});
            chk({tag, " last mark"}, {31'd0, cap_l[(c0 + j) % 256]}, {31'd0, j == exp_bytes - 1});
        end
        chk({tag, " R5 write count"}, 32'(wr_n - w0), 32'd2);
        chk({tag, " R5 status addr"}, {9'd0, wr_a[w0 % 64]}, DESC0 + 3);
        chk({tag, " status word"}, {16'd0, wr_d[w0 % 64]}, {16'd0, exp_misc});
        chk({tag, " R5 own write last"}, {9'd0, wr_a[(w0 + 1) % 64]}, DESC0 + 1);
        chk({tag, " flag word"}, {16'd0, wr_d[(w0 + 1) % 64]}, {16'd0, exp_flag});
        chk({tag, " R10 next entry read, scan stops"}, {9'd0, rd_a[(rd_n - 1) % 256]}, DESC0 + 5);
        chk({tag, " R5 single pulse"}, 32'(done_n - d0), 32'd1);
        mac_retries <= '0;
        mac_lost_carrier <= 1'b0;
        mac_late_collision <= 1'b0;
        mac_underflow <= 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'd0, tx_valid}, 0);
        chk("R1 mem_en in reset", {31'd0, mem_en}, 0);
        rst_n <= 1'b1;
        @(negedge clk);
        chk("R1 done after reset", {31'd0, tx_done}, 0);
        chk("R1 mem_en after reset", {31'd0, mem_en}, 0);
    endtask

    task automatic t_host_owned();
        int r0;
        int w0;
        int c0;
        @(negedge clk);
        run <= 1'b0;
        set_desc(0, 16'h0400, 8'h03, 8);
        @(negedge clk);
        r0 = rd_n;
        w0 = wr_n;
        c0 = cap_n;
        run <= 1'b1;
        poll_demand <= 1'b1;
        @(negedge clk);
        poll_demand <= 1'b0;
        chk("R11 demand read now", {31'd0, mem_en && !mem_we}, 1);
        chk("R3 flag word address", {9'd0, mem_addr}, DESC0 + 1);
        repeat (10) @(negedge clk);
        chk("R2 single read", 32'(rd_n - r0), 1);
        chk("R2 no write", 32'(wr_n - w0), 0);
        chk("R2 no bytes", 32'(cap_n - c0), 0);
        run <= 1'b0;
    endtask

    task automatic t_wrap();
        int w0;
        int d0;
        @(negedge clk);
        run <= 1'b0;
        ring_cfg <= {3'd1, 13'd0};
        set_desc(0, 16'h0400, 8'h83, 2);
        set_desc(1, 16'h0440, 8'h83, 3);
        fill_buf(16'h0400, 2, 5);
        fill_buf(16'h0440, 3, 6);
        @(negedge clk);
        w0 = wr_n;
        d0 = done_n;
        kick();
        wait_done(d0 + 2, "R9 two completions");
        chk("R9 entry0 own write", {9'd0, wr_a[(w0 + 1) % 64]}, DESC0 + 1);
        chk("R9 entry1 own write", {9'd0, wr_a[(w0 + 3) % 64]}, DESC0 + 5);
        chk("R9 wrap to entry0", {9'd0, rd_a[(rd_n - 1) % 256]}, DESC0 + 1);
        chk("R9 stops after wrap", 32'(wr_n - w0), 4);
        ring_cfg <= {3'd2, 13'd0};
    endtask

    task automatic t_periodic();
        int r0;
        @(negedge clk);
        run <= 1'b0;
        set_desc(0, 16'h0400, 8'h03, 8);
        @(negedge clk);
        r0 = rd_n;
        run <= 1'b1;
        repeat (10 * (POLL + 2)) @(negedge clk);
        chk("R11 periodic scan count", 32'((rd_n - r0) >= 9 && (rd_n - r0) <= 11), 1);
        chk("R11 periodic address", {9'd0, rd_a[(rd_n - 1) % 256]}, DESC0 + 1);
        run <= 1'b0;
    endtask

    task automatic t_stop();
        int r0;
        @(negedge clk);
        run <= 1'b0;
        rdy_mode = 2;
        set_desc(0, 16'h0400, 8'h83, 20);
        fill_buf(16'h0400, 20, 9);
        @(negedge clk);
        kick();
        repeat (12) @(negedge clk);
        chk("R12 stream stalled", {31'd0, tx_valid}, 1);
        run <= 1'b0;
        @(negedge clk);
        r0 = rd_n;
        poll_demand <= 1'b1;
        repeat (20) @(negedge clk);
        poll_demand <= 1'b0;
        chk("R12 no bytes offered", {31'd0, tx_valid}, 0);
        chk("R12 no memory access", 32'(rd_n - r0), 0);
        rdy_mode = 0;
        run <= 1'b1;
        poll_demand <= 1'b1;
        @(negedge clk);
        poll_demand <= 1'b0;
        chk("R12 index back at 0", {9'd0, mem_addr}, DESC0 + 1);
        wait_done(done_n + 1, "R12 restart completes");
        run <= 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        t_reset();
        t_host_owned();
        one_frame("R4 basic", 8'h83, 16'h0400, 5, 1, 5'd0, 0, 0, 0, 10'h155,
                  16'h0155, 16'h0300, 5);
        rdy_mode = 1;
        one_frame("R4 odd start backpressure", 8'h83, 16'h0405, 7, 2, 5'd0, 0, 0, 0, 10'h000,
                  16'h0000, 16'h0300, 7);
        rdy_mode = 0;
        one_frame("R6 one retry", 8'h83, 16'h0400, 4, 3, 5'd1, 0, 0, 0, 10'h001,
                  16'h0001, 16'h0B00, 4);
        one_frame("R6 several retries", 8'h83, 16'h0400, 4, 4, 5'd3, 0, 0, 0, 10'h002,
                  16'h0002, 16'h1300, 4);
        one_frame("R6 retry failure", 8'h83, 16'h0400, 4, 5, 5'd20, 0, 0, 0, 10'h003,
                  16'h0403, 16'h5300, 4);
        one_frame("R7 lost carrier", 8'h83, 16'h0400, 4, 6, 5'd0, 1, 0, 0, 10'h3FF,
                  16'h0BFF, 16'h4300, 4);
        one_frame("R7 late collision", 8'h83, 16'h0400, 4, 7, 5'd0, 0, 1, 0, 10'h010,
                  16'h1010, 16'h4300, 4);
        one_frame("R7 underflow", 8'h83, 16'h0400, 4, 8, 5'd0, 0, 0, 1, 10'h020,
                  16'h4020, 16'h4300, 4);
        one_frame("R8 no end mark", 8'h82, 16'h0400, 4, 9, 5'd0, 0, 0, 0, 10'h0AA,
                  16'h8000, 16'h4200, 0);
        t_wrap();
        t_periodic();
        t_stop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule